// File: doc/BRIEF.md
# Standby Clock Sequencer

This block controls the clocks during standby. While the core runs normally, a single idle command from the core moves the block into one of four standby modes. Three configuration inputs, sampled when that command arrives, select the mode:

- **Idle** keeps every clock running. Only the core is halted.
- **Core power-down** gates the core clock.
- **Core and peripheral power-down** also gates the peripheral clock.
- **Full power-down** also removes the PLL enable.

A wake interrupt ends standby. The block then turns the missing enables back on, one per cycle, in a fixed order: PLL first, then the peripheral clock, then the core clock. A fixed number of cycles after the core clock is back, the block releases the core with a one-cycle resume pulse. The sequence is therefore always the same for a given mode.

Only the enable sequencing is modelled. The gating cells, the PLL and pipeline retention are not part of this block. Internally, a control state machine (running, one state per standby mode, waking) sends small command strobes to a datapath. The datapath owns the enable vector, the halt flag and the resume counter.

Top module: `standby_clock_sequencer`

## Requirements
- R1: During and right after reset, `coreClkEn`, `periphClkEn` and `pllEn` are 1, and `coreHalted` and `resumePulse` are 0.
- R2: When `idleStrobe` is sampled high while running and `cfgPowerDown`=0, the cycle after that edge shows `coreHalted`=1 with all three enables still 1, whatever `cfgStall` and `cfgStopClock` are.
- R3: When `idleStrobe` is sampled high while running with `cfgPowerDown`=1 and `cfgStall`=1, the next cycle shows `coreClkEn`=0 while `periphClkEn`=1 and `pllEn`=1.
- R4: When `idleStrobe` is sampled high while running with `cfgPowerDown`=1, `cfgStall`=0 and `cfgStopClock`=0, the next cycle shows `coreClkEn`=0, `periphClkEn`=0 and `pllEn`=1.
- R5: When `idleStrobe` is sampled high while running with `cfgPowerDown`=1, `cfgStall`=0 and `cfgStopClock`=1, all three enables are 0 in the next cycle.
- R6: While `coreHalted`=1, `idleStrobe` and the configuration inputs have no effect: no enable drops, and the standby mode and wake timing stay those chosen on entry.
- R7: `wakeIrq` has no effect while running: the enables stay 1, `coreHalted` stays 0 and no resume pulse occurs.
- R8: A wake is taken at the first edge where `wakeIrq` is sampled high in a standby mode. From that edge on, one missing enable returns per edge, in the order PLL, peripheral, core.
- R9: `resumePulse` is high for exactly one cycle, and `coreHalted` falls in that same cycle. With `RESUME_LAT`=2 the pulse appears 2 edges after the edge that restored the core clock. In Idle mode, where the core clock was never gated, it appears 2 edges after the wake edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| idleStrobe | input | 1 | One-cycle idle command from the core |
| cfgPowerDown | input | 1 | Configuration bit: power-down select |
| cfgStopClock | input | 1 | Configuration bit: stop-clock select |
| cfgStall | input | 1 | Configuration bit: stall select |
| wakeIrq | input | 1 | Wake interrupt request, level |
| coreClkEn | output | 1 | Core clock enable |
| periphClkEn | output | 1 | Peripheral clock enable |
| pllEn | output | 1 | PLL enable |
| coreHalted | output | 1 | Core held from executing |
| resumePulse | output | 1 | One-cycle release of the core after wake |

## Verification
The bench builds the block with the default `RESUME_LAT`=2, which is the two-cycle resume latency the requirements call for. With this value the wake sequence is short: 2 edges for Idle and core power-down, 3 for core and peripheral power-down, and 4 for full power-down. Every edge of every sequence can therefore be compared against a bench model, including the cycle after the pulse. Random configuration bits, random standby durations, and idle strobes injected while halted and while waking cover all four modes many times. Directed cases cover reset and a wake request sent while the core is running.

// File: rtl/sbc_pkg.sv
`timescale 1ns/1ps
package sbc_pkg;

  // Mode value equals the number of gated domains (counted from the core side).
  typedef enum logic [1:0] {
    MODE_IDLE        = 2'd0,
    MODE_CORE        = 2'd1,
    MODE_CORE_PERIPH = 2'd2,
    MODE_ALL         = 2'd3
  } lpMode_t;

  typedef struct packed {
    logic    enter;  // leave running state, gate per mode
    lpMode_t mode;
    logic    wake;   // wake edge: first restore step
    logic    step;   // waking state: continue restore / resume count
  } seqCmd_t;

  function automatic lpMode_t decodeMode(input logic powerDown,
                                         input logic stopClk,
                                         input logic stall);
    if (!powerDown)  return MODE_IDLE;
    else if (stall)  return MODE_CORE;
    else if (stopClk) return MODE_ALL;
    else             return MODE_CORE_PERIPH;
  endfunction

endpackage

// File: rtl/sbc_ctrl.sv
`timescale 1ns/1ps
module sbc_ctrl
  import sbc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    idleStrobe,
  input  logic    cfgPowerDown,
  input  logic    cfgStopClock,
  input  logic    cfgStall,
  input  logic    wakeIrq,
  input  logic    seqDone,
  output seqCmd_t cmd
);

  typedef enum logic [2:0] {
    ST_RUN, ST_IDLE, ST_PD_CORE, ST_PD_CP, ST_PD_ALL, ST_WAKE
  } state_t;

  state_t  state, nextState;
  lpMode_t reqMode;

  assign reqMode = decodeMode(cfgPowerDown, cfgStopClock, cfgStall);

  always_comb begin
    nextState = state;
    cmd       = '0;
    unique case (state)
      ST_RUN: begin
        if (idleStrobe) begin
          cmd.enter = 1'b1;
          cmd.mode  = reqMode;
          unique case (reqMode)
            MODE_IDLE:        nextState = ST_IDLE;
            MODE_CORE:        nextState = ST_PD_CORE;
            MODE_CORE_PERIPH: nextState = ST_PD_CP;
            default:          nextState = ST_PD_ALL;
          endcase
        end
      end
      ST_IDLE, ST_PD_CORE, ST_PD_CP, ST_PD_ALL: begin
        if (wakeIrq) begin
          cmd.wake  = 1'b1;
          nextState = ST_WAKE;
        end
      end
      ST_WAKE: begin
        cmd.step = 1'b1;
        if (seqDone) nextState = ST_RUN;
      end
      default: nextState = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_RUN;
    else       state <= nextState;
  end

endmodule

// File: rtl/sbc_enables.sv
`timescale 1ns/1ps
module sbc_enables
  import sbc_pkg::*;
#(
  parameter int RESUME_LAT = 2,
  parameter int NUM_DOM    = 3   // index 0 = PLL, 1 = peripheral, 2 = core
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqCmd_t            cmd,
  output logic [NUM_DOM-1:0] domEn,
  output logic               coreHalted,
  output logic               resumePulse,
  output logic               seqDone
);

  localparam int CNT_W = (RESUME_LAT < 2) ? 1 : $clog2(RESUME_LAT + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RESUME_LAT - 1);

  logic [CNT_W-1:0]   resumeCnt;
  logic [NUM_DOM-1:0] gateMask, restoreMask;
  logic               allOn;

  assign allOn   = &domEn;
  assign seqDone = cmd.step && allOn && (resumeCnt == CNT_LAST);

  // Gated domains are the top `mode` indices of the vector.
  for (genvar i = 0; i < NUM_DOM; i++) begin : g_gate
    assign gateMask[i] = (i >= NUM_DOM - int'(cmd.mode));
  end

  // Lowest-index gated domain is restored first.
  always_comb begin
    logic found;
    found       = 1'b0;
    restoreMask = '0;
    for (int i = 0; i < NUM_DOM; i++) begin
      if (!domEn[i] && !found) begin
        restoreMask[i] = 1'b1;
        found          = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      domEn       <= '1;
      coreHalted  <= 1'b0;
      resumePulse <= 1'b0;
      resumeCnt   <= '0;
    end else begin
      resumePulse <= seqDone;
      if (cmd.enter) begin
        domEn      <= domEn & ~gateMask;
        coreHalted <= 1'b1;
        resumeCnt  <= '0;
      end else if (cmd.wake || cmd.step) begin
        if (!allOn) begin
          domEn     <= domEn | restoreMask;
          resumeCnt <= '0;
        end else if (seqDone) begin
          coreHalted <= 1'b0;
          resumeCnt  <= '0;
        end else if (cmd.wake) begin
          resumeCnt <= '0;
        end else begin
          resumeCnt <= resumeCnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/standby_clock_sequencer.sv
`timescale 1ns/1ps
module standby_clock_sequencer
  import sbc_pkg::*;
#(
  parameter int RESUME_LAT = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic idleStrobe,
  input  logic cfgPowerDown,
  input  logic cfgStopClock,
  input  logic cfgStall,
  input  logic wakeIrq,
  output logic coreClkEn,
  output logic periphClkEn,
  output logic pllEn,
  output logic coreHalted,
  output logic resumePulse
);

  localparam int NUM_DOM = 3;

  seqCmd_t            cmd;
  logic               seqDone;
  logic [NUM_DOM-1:0] domEn;

  sbc_ctrl i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .idleStrobe   (idleStrobe),
    .cfgPowerDown (cfgPowerDown),
    .cfgStopClock (cfgStopClock),
    .cfgStall     (cfgStall),
    .wakeIrq      (wakeIrq),
    .seqDone      (seqDone),
    .cmd          (cmd)
  );

  sbc_enables #(.RESUME_LAT(RESUME_LAT), .NUM_DOM(NUM_DOM)) i_enables (
    .clk         (clk),
    .rstN        (rstN),
    .cmd         (cmd),
    .domEn       (domEn),
    .coreHalted  (coreHalted),
    .resumePulse (resumePulse),
    .seqDone     (seqDone)
  );

  assign pllEn       = domEn[0];
  assign periphClkEn = domEn[1];
  assign coreClkEn   = domEn[2];

endmodule

// File: rtl/sbc_checker.sv
`timescale 1ns/1ps
module sbc_checker (
  input logic clk,
  input logic rstN,
  input logic idleStrobe,
  input logic cfgPowerDown,
  input logic cfgStopClock,
  input logic cfgStall,
  input logic wakeIrq,
  input logic coreClkEn,
  input logic periphClkEn,
  input logic pllEn,
  input logic coreHalted,
  input logic resumePulse
);

  p_idle_keeps_clocks_r2: assert property (@(posedge clk) disable iff (!rstN)
    (idleStrobe && !coreHalted && !cfgPowerDown) |=>
      (coreHalted && coreClkEn && periphClkEn && pllEn));

  p_core_gated_r3: assert property (@(posedge clk) disable iff (!rstN)
    (idleStrobe && !coreHalted && cfgPowerDown && cfgStall) |=>
      (!coreClkEn && periphClkEn && pllEn));

  p_core_periph_gated_r4: assert property (@(posedge clk) disable iff (!rstN)
    (idleStrobe && !coreHalted && cfgPowerDown && !cfgStall && !cfgStopClock) |=>
      (!coreClkEn && !periphClkEn && pllEn));

  p_all_gated_r5: assert property (@(posedge clk) disable iff (!rstN)
    (idleStrobe && !coreHalted && cfgPowerDown && !cfgStall && cfgStopClock) |=>
      (!coreClkEn && !periphClkEn && !pllEn));

  p_no_drop_halted_r6: assert property (@(posedge clk) disable iff (!rstN)
    coreHalted |=> !($fell(coreClkEn) || $fell(periphClkEn) || $fell(pllEn)));

  p_wake_ignored_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!coreHalted && wakeIrq && !idleStrobe) |=>
      (!coreHalted && coreClkEn && periphClkEn && pllEn));

  p_order_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!pllEn |-> !periphClkEn) and (!periphClkEn |-> !coreClkEn));

  p_pulse_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    resumePulse |=> !resumePulse);

  p_pulse_after_core_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resumePulse) |-> ($past(coreClkEn, 1) && $past(coreClkEn, 2)));

  p_halt_release_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(coreHalted) |-> resumePulse);

endmodule

bind standby_clock_sequencer sbc_checker i_chk (.*);

// File: tb/test_standby_clock_sequencer.sv
`timescale 1ns/1ps
module test_standby_clock_sequencer;

  localparam int LAT = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic idleStrobe = 1'b0, cfgPowerDown = 1'b0, cfgStopClock = 1'b0, cfgStall = 1'b0;
  logic wakeIrq = 1'b0;
  logic coreClkEn, periphClkEn, pllEn, coreHalted, resumePulse;

  int nRun = 0, nFail = 0, cyc = 0;

  standby_clock_sequencer #(.RESUME_LAT(LAT)) i_standby_clock_sequencer (
    .clk(clk), .rstN(rstN), .idleStrobe(idleStrobe), .cfgPowerDown(cfgPowerDown),
    .cfgStopClock(cfgStopClock), .cfgStall(cfgStall), .wakeIrq(wakeIrq),
    .coreClkEn(coreClkEn), .periphClkEn(periphClkEn), .pllEn(pllEn),
    .coreHalted(coreHalted), .resumePulse(resumePulse)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nFail++;
      $display("FAIL watchdog (R1..R9 run) actual=%0d cycles expected<150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  // Gated domains per configuration: 0 Idle, 1 core, 2 core+periph, 3 all.
  function automatic int offCount(bit pd, bit stop, bit stall);
    if (!pd) return 0;
    if (stall) return 1;
    return stop ? 3 : 2;
  endfunction

  // {core, periph, pll}; domain i (0=pll) is on when i < 3-(off-restored).
  function automatic logic [2:0] expEn(int off, int restored);
    logic [2:0] v;
    for (int i = 0; i < 3; i++) v[i] = (i < 3 - (off - restored));
    return {v[2], v[1], v[0]};
  endfunction

  function automatic int wakeLat(int off);
    return ((off == 0) ? 0 : off - 1) + LAT;
  endfunction

  function automatic string modeReq(int off);
    case (off)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic runCase(bit pd, bit stop, bit stall, int gap, bit noise);
    int off, lat, restored;
    off = offCount(pd, stop, stall);
    cfgPowerDown = pd; cfgStopClock = stop; cfgStall = stall;
    idleStrobe = 1'b1;
    tick();
    idleStrobe = 1'b0;
    check(modeReq(off), {coreClkEn, periphClkEn, pllEn}, expEn(off, 0), "enables on entry");
    check(modeReq(off), coreHalted, 1, "halted on entry");
    check(modeReq(off), resumePulse, 0, "no pulse on entry");
    for (int g = 0; g < gap; g++) begin
      if (noise) begin
        idleStrobe = 1'($urandom); cfgPowerDown = 1'($urandom);
        cfgStopClock = 1'($urandom); cfgStall = 1'($urandom);
      end
      tick();
      check("R6", {coreClkEn, periphClkEn, pllEn}, expEn(off, 0), "enables while halted");
      check("R6", coreHalted, 1, "still halted");
    end
    idleStrobe = 1'b0;
    wakeIrq = 1'b1;
    tick();
    wakeIrq = 1'b0;
    lat = wakeLat(off);
    for (int k = 0; k <= lat + 1; k++) begin
      restored = (k + 1 < off) ? k + 1 : off;
      check("R8", {coreClkEn, periphClkEn, pllEn}, expEn(off, restored), "restore order");
      check("R9", resumePulse, (k == lat), "resume pulse timing");
      check("R9", coreHalted, (k < lat), "halt release timing");
      if (k <= lat) begin
        idleStrobe = noise && (k < lat);   // R6: strobes during waking are ignored
        wakeIrq = noise ? 1'($urandom) : 1'b0;
        tick();
      end
    end
    idleStrobe = 1'b0;
    wakeIrq = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    // R1: reset state
    repeat (3) tick();
    check("R1", {coreClkEn, periphClkEn, pllEn, coreHalted, resumePulse}, 5'b11100, "in reset");
    rstN = 1'b1;
    tick();
    check("R1", {coreClkEn, periphClkEn, pllEn, coreHalted, resumePulse}, 5'b11100, "after reset");

    // R7: wake request while running
    wakeIrq = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      check("R7", {coreClkEn, periphClkEn, pllEn, coreHalted, resumePulse}, 5'b11100, "wake while running");
    end
    wakeIrq = 1'b0;
    tick();

    // Directed: each mode, Idle also with don't-care bits set (R2..R5)
    runCase(0, 0, 0, 0, 0);
    runCase(0, 1, 1, 2, 0);
    runCase(1, 0, 1, 1, 0);
    runCase(1, 1, 1, 3, 1);
    runCase(1, 0, 0, 0, 0);
    runCase(1, 1, 0, 4, 1);
    runCase(1, 1, 0, 0, 0);

    // Random mix
    for (int n = 0; n < 60; n++) begin
      runCase(1'($urandom), 1'($urandom), 1'($urandom), int'($urandom_range(0, 6)), 1'($urandom));
      repeat ($urandom_range(0, 2)) tick();
    end

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule